// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block moves a device into a low-power state and back out. Software asks for shutdown with a single write strobe. The block then waits a fixed number of processor clocks so that the core can halt itself. After that wait it raises a power-down signal. That signal forces off the oscillator, the PLL, the bias and reference circuits and several peripheral enables, and it stops the processor clock through a clock-run output.

Ten wake sources are combined with a logical OR:
- eight user interrupt lines,
- a smart-card event,
- a keypad event.

A wake event is caught by a sticky flag that sets asynchronously, so detection works while no clock runs. The flag at once drops the power-down signal, which restarts the clock. Once the clock is back, the flag passes through a two-stage synchronizer. A 512-cycle settling count then runs, and after it the block delivers a one-cycle pulse on the INT0 request line.

A wake-routing configuration bit must be high at the moment the power-down request is accepted. Only then are wake sources armed. Without it, the block stays powered down until reset. A wake event during the entry delay cancels the shutdown.

Top module: `pwr_seq_top`

## Requirements
- R1: A `pd_set` pulse captured in the RUN state makes `pd_out` rise exactly 32 clock edges after the capturing edge; `pd_out` is low after edge 31.
- R2: While `pd_out` is high, all seven bits of `en_out` are 0. Otherwise `en_out` equals `en_req`. Bit map: [0] high-speed oscillator, [1] PLL/VCO, [2] reference and bias, [3] analog comparator, [4] supply-fault detector, [5] card supply, [6] flash read-pulse one-shot.
- R3: The wake request is the OR of `usr_irq[7:0]`, `card_irq` and `keypad_irq`. Any single source, held for a short time only, wakes the block.
- R4: Wake sources are armed only if `wake_mux_en` is 1 at the edge that captures `pd_set`. If it is 0, the block stays in POWERED_DOWN with `pd_out` high and never pulses `int0` until `rst`.
- R5: An armed wake event drops `pd_out` and raises `clk_run` at once, without waiting for a clock edge. `clk_run` is the inverse of `pd_out`.
- R6: After a wake from POWERED_DOWN, count edges from the first edge after the event. `int0` is low after edge 514, high for exactly one cycle after edge 515, and the state is then RUN.
- R7: Clearing every bit of `en_req` neither raises `pd_out` nor lowers `clk_run`. Shutdown comes only through `pd_set`.
- R8: `pd_bit` reads 1 from the capturing edge until the wake sequence ends, then clears by itself. A further `pd_set` during the entry delay is ignored and does not restart the delay.
- R9: An armed wake event during the entry delay returns the block to RUN after the third edge following the event, with a one-cycle `int0` pulse. `pd_out` never rises and `pd_bit` clears.
- R10: `state` encodes RUN=0, ENTRY_DELAY=1, POWERED_DOWN=2, WAKE_SETTLE=3. The synchronous active-high `rst` returns RUN with `pd_out`=0, `pd_bit`=0, `int0`=0 and `en_out`=`en_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_set | input | 1 | Power-down request write strobe |
| wake_mux_en | input | 1 | Wake-routing configuration bit |
| usr_irq | input | 8 | User interrupt wake sources |
| card_irq | input | 1 | Smart-card event wake source |
| keypad_irq | input | 1 | Keypad event wake source |
| en_req | input | 7 | Software enable bits for the gated functions |
| en_out | output | 7 | Enables after power-down gating |
| pd_out | output | 1 | Power-down signal to analog and clock circuits |
| clk_run | output | 1 | Clock subsystem run request |
| pd_bit | output | 1 | Readback of the power-down control bit |
| int0 | output | 1 | Wake interrupt pulse to the processor |
| state | output | 2 | Sequencer state |

## Verification
A table of wake patterns drives full shutdown and wake cycles. The patterns are a lone low user line, the top user line, the card event alone, the keypad event alone, and all sources together. Together they show whether every input really feeds the OR and whether the settle count is the same for every source. Directed cases follow. A wake inside the entry window tells an abort apart from a late shutdown. A second request inside the window shows whether the delay restarts. A shutdown with routing disabled must never wake. Clearing all enables must not count as a shutdown.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ENTRY  = 2'd1,
    ST_DOWN   = 2'd2,
    ST_SETTLE = 2'd3
  } pwr_state_e;

  localparam int NUM_EN  = 7;
  localparam int NUM_USR = 8;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int NUM_USR     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_USR-1:0] usr_irq,
  input  logic               card_irq,
  input  logic               keypad_irq,
  input  logic               armed,
  input  logic               clr,
  output logic               wake_flag,
  output logic               wake_sync
);
  logic wake_any;
  logic wake_set;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    wake_any = (|usr_irq) | card_irq | keypad_irq;
    wake_set = wake_any & armed;
  end

  // sticky flag: sets without a clock, clears only on a clock edge
  always_ff @(posedge clk or posedge wake_set) begin
    if (wake_set)        wake_flag <= 1'b1;
    else if (rst || clr) wake_flag <= 1'b0;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst || clr) sync_q <= '0;
        else            sync_q <= wake_flag;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst || clr) sync_q <= '0;
        else            sync_q <= {sync_q[SYNC_STAGES-2:0], wake_flag};
      end
    end
  endgenerate

  assign wake_sync = sync_q[SYNC_STAGES-1];

  // R3: once caught, the wake event is held until cleared
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (wake_flag && !clr) |=> wake_flag);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int ENTRY_CYC  = 32,
  parameter int SETTLE_CYC = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_set,
  input  logic       mux_en,
  input  logic       wake_sync,
  output pwr_state_e st,
  output logic       pd_active,
  output logic       pd_bit,
  output logic       armed,
  output logic       clr,
  output logic       int0
);
  localparam int MAXC = (SETTLE_CYC > ENTRY_CYC) ? SETTLE_CYC : ENTRY_CYC;
  localparam int CW   = $clog2(MAXC);
  localparam logic [CW-1:0] ENTRY_LAST  = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    clr = ((st == ST_SETTLE) && (cnt == SETTLE_LAST)) ||
          ((st == ST_ENTRY) && wake_sync);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      cnt       <= '0;
      pd_active <= 1'b0;
      pd_bit    <= 1'b0;
      armed     <= 1'b0;
      int0      <= 1'b0;
    end else begin
      int0 <= 1'b0;
      case (st)
        ST_RUN: if (pd_set) begin
          st     <= ST_ENTRY;
          cnt    <= '0;
          pd_bit <= 1'b1;
          armed  <= mux_en;
        end
        ST_ENTRY: begin
          if (wake_sync) begin
            st     <= ST_RUN;
            pd_bit <= 1'b0;
            armed  <= 1'b0;
            int0   <= 1'b1;
          end else if (cnt == ENTRY_LAST) begin
            st        <= ST_DOWN;
            pd_active <= 1'b1;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DOWN: if (wake_sync) begin
          st        <= ST_SETTLE;
          pd_active <= 1'b0;
          cnt       <= '0;
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            st     <= ST_RUN;
            pd_bit <= 1'b0;
            armed  <= 1'b0;
            int0   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  // R1: shutdown is only reached from the entry delay
  p_down_after_entry_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> $past(st) == ST_ENTRY);
  // R6: interrupt is a single-cycle pulse
  p_int0_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    int0 |=> !int0);
  // R8: control bit stays set while the sequence is busy
  p_bit_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_RUN) |-> pd_bit);
  // R6: leaving settle always delivers the interrupt
  p_settle_exit_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_SETTLE && st == ST_RUN) |-> int0);
endmodule

// File: rtl/pwr_en_gate.sv
module pwr_en_gate #(
  parameter int NUM_EN = 7
) (
  input  logic [NUM_EN-1:0] en_req,
  input  logic              pd_sig,
  output logic [NUM_EN-1:0] en_out
);
  generate
    for (genvar i = 0; i < NUM_EN; i++) begin : g_bit
      assign en_out[i] = en_req[i] & ~pd_sig;
    end
  endgenerate

  // R2: every gated enable is off during power-down
  always_comb begin
    if (pd_sig === 1'b1) p_all_off_r2: assert (en_out == '0);
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int ENTRY_CYC  = 32,
  parameter int SETTLE_CYC = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd_set,
  input  logic               wake_mux_en,
  input  logic [NUM_USR-1:0] usr_irq,
  input  logic               card_irq,
  input  logic               keypad_irq,
  input  logic [NUM_EN-1:0]  en_req,
  output logic [NUM_EN-1:0]  en_out,
  output logic               pd_out,
  output logic               clk_run,
  output logic               pd_bit,
  output logic               int0,
  output logic [1:0]         state
);
  pwr_state_e st;
  logic pd_active, armed, clr, wake_flag, wake_sync;

  pwr_wake_detect #(.NUM_USR(NUM_USR), .SYNC_STAGES(2)) u_wake (
    .clk(clk), .rst(rst), .usr_irq(usr_irq), .card_irq(card_irq),
    .keypad_irq(keypad_irq), .armed(armed), .clr(clr),
    .wake_flag(wake_flag), .wake_sync(wake_sync)
  );

  pwr_seq_ctrl #(.ENTRY_CYC(ENTRY_CYC), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .pd_set(pd_set), .mux_en(wake_mux_en),
    .wake_sync(wake_sync), .st(st), .pd_active(pd_active), .pd_bit(pd_bit),
    .armed(armed), .clr(clr), .int0(int0)
  );

  // the asynchronous wake flag releases power-down before any clock edge
  assign pd_out  = pd_active & ~wake_flag;
  assign clk_run = ~pd_out;
  assign state   = st;

  pwr_en_gate #(.NUM_EN(NUM_EN)) u_gate (
    .en_req(en_req), .pd_sig(pd_out), .en_out(en_out)
  );

  // R7: no power-down in the run state, whatever the enable bits
  p_run_no_pd_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> !pd_out);
  // R4: without arming, power-down is held
  p_unarmed_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DOWN && !armed) |=> (st == ST_DOWN && pd_out));
endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_set = 1'b0;
  logic       wake_mux_en = 1'b0;
  logic [7:0] usr_irq = '0;
  logic       card_irq = 1'b0;
  logic       keypad_irq = 1'b0;
  logic [6:0] en_req = 7'h7F;
  logic [6:0] en_out;
  logic       pd_out, clk_run, pd_bit, int0;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq_top dut_i (
    .clk(clk), .rst(rst), .pd_set(pd_set), .wake_mux_en(wake_mux_en),
    .usr_irq(usr_irq), .card_irq(card_irq), .keypad_irq(keypad_irq),
    .en_req(en_req), .en_out(en_out), .pd_out(pd_out), .clk_run(clk_run),
    .pd_bit(pd_bit), .int0(int0), .state(state)
  );

  // wake vector bits: [7:0] usr_irq, [8] card_irq, [9] keypad_irq
  localparam logic [9:0] WAKE_VEC [5] = '{10'h001, 10'h080, 10'h100, 10'h200, 10'h3FF};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic request_pd();
    pd_set = 1'b1; tick(); pd_set = 1'b0;
  endtask

  task automatic pulse_wake(input logic [9:0] v);
    usr_irq = v[7:0]; card_irq = v[8]; keypad_irq = v[9];
    #0.5;
    usr_irq = '0; card_irq = 1'b0; keypad_irq = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk(state == 2'd0, "R10", state, 0);
    chk(pd_out == 0 && pd_bit == 0 && int0 == 0, "R10", {pd_out, pd_bit, int0}, 0);
    chk(en_out == en_req, "R10", en_out, en_req);

    wake_mux_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      bit seen_early;
      en_req = 7'h7F ^ 7'(k);
      request_pd();
      chk(pd_bit == 1 && state == 2'd1, "R8", {pd_bit, state}, 3'b101);
      for (int c = 1; c < 32; c++) tick();
      chk(pd_out == 0, "R1", pd_out, 0);
      tick();
      chk(pd_out == 1 && state == 2'd2, "R1", {pd_out, state}, 3'b110);
      chk(en_out == 0 && clk_run == 0, "R2", {en_out, clk_run}, 0);
      pulse_wake(WAKE_VEC[k]);
      chk(pd_out == 0 && clk_run == 1, "R5", {pd_out, clk_run}, 2'b01);
      chk(en_out == en_req, "R2", en_out, en_req);
      seen_early = 0;
      for (int c = 1; c < 515; c++) begin
        tick();
        if (int0) seen_early = 1;
      end
      chk(!seen_early && state == 2'd3, "R3", {seen_early, state}, 3'b011);
      tick();
      chk(int0 == 1 && state == 2'd0, "R6", {int0, state}, 3'b100);
      chk(pd_bit == 0, "R8", pd_bit, 0);
      tick();
      chk(int0 == 0, "R6", int0, 0);
    end

    // R8: repeated request inside the window does not restart the delay
    request_pd();
    for (int c = 1; c < 10; c++) tick();
    request_pd();
    for (int c = 11; c < 32; c++) tick();
    chk(pd_out == 0, "R8", pd_out, 0);
    tick();
    chk(pd_out == 1, "R8", pd_out, 1);
    pulse_wake(10'h004);
    for (int c = 0; c < 520; c++) tick();
    chk(state == 2'd0 && pd_out == 0, "R8", {state, pd_out}, 0);

    // R9: wake during entry aborts
    request_pd();
    for (int c = 1; c < 6; c++) tick();
    pulse_wake(10'h010);
    tick(); tick();
    chk(state == 2'd1 && int0 == 0, "R9", {state, int0}, 3'b010);
    tick();
    chk(state == 2'd0 && int0 == 1 && pd_bit == 0, "R9", {state, int0, pd_bit}, 4'b0010);
    begin
      bit rose = 0;
      for (int c = 0; c < 40; c++) begin tick(); if (pd_out) rose = 1; end
      chk(!rose, "R9", rose, 0);
    end

    // R7: clearing every enable is not a shutdown
    en_req = 7'h00;
    for (int c = 0; c < 40; c++) tick();
    chk(pd_out == 0 && clk_run == 1 && state == 2'd0, "R7", {pd_out, clk_run, state}, 4'b0100);
    en_req = 7'h55;

    // R4: no routing, no wake
    wake_mux_en = 1'b0;
    request_pd();
    wake_mux_en = 1'b1;
    for (int c = 1; c < 32; c++) tick();
    tick();
    chk(pd_out == 1, "R4", pd_out, 1);
    pulse_wake(10'h3FF);
    chk(pd_out == 1, "R4", pd_out, 1);
    begin
      bit got = 0;
      for (int c = 0; c < 600; c++) begin tick(); if (int0) got = 1; end
      chk(!got && state == 2'd2 && pd_out == 1, "R4", {got, state, pd_out}, 4'b0101);
    end
    do_reset();
    chk(state == 2'd0 && pd_out == 0 && en_out == en_req, "R10", {state, pd_out}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule